// File: doc/BRIEF.md
# Sleep Control Register and Staged Sleep Sequencer

This block holds one 32-bit power-management control register on a simple I/O write/read port. Software writes a 3-bit sleep code and, in the same write, sets a write-only "go" bit. If the sequencer is resting in the on state and the code names a real sleep state, three active-low stage outputs are pulled low one after another, a fixed number of clock cycles apart. The depth depends on the code: standby, suspend-to-RAM, suspend-to-disk or soft off. A wake input walks the stages back up in reverse order. When the last stage is released, the stored code clears to zero.

One code has two possible meanings, chosen by a parameter. In the desktop mapping, code 001 halts the processor clock and may also drive a processor sleep pin, and code 010 does nothing. In the mobile mapping, code 010 asserts only the first stage, and code 001 does nothing.

The same register holds a routing bit that sends incoming power-management events to either the SCI or the SMI interrupt output. It also holds a bus-master reload bit that lets bus-master requests break the processor out of deep idle. A further write-only bit raises a one-cycle event toward firmware.

Top module: `pm_sleep_ctl`

## Requirements
- R1: After reset the register reads 0000_0000h. All five active-low sleep outputs are high. All four event outputs are low.
- R2: The following bits are read/write: bit 0 (event routing), bit 1 (bus-master reload) and bits 12:10 (sleep code). Bit 13 (go) and bit 2 (firmware kick) are write-only and read as 0, and every other bit reads as 0. Writing FFFF_DFFFh reads back 0000_1C03h.
- R3: A write with bit 13 = 1 and code 101 drives `stage1_n` low GAP+1 edges after the write edge and `stage2_n` low GAP edges later. `stage3_n` stays high.
- R4: Codes 110 and 111 drive `stage1_n`, `stage2_n` and `stage3_n` low in that order. The first goes low GAP+1 edges after the write edge, and each of the others follows GAP edges after the one before.
- R5: With the default desktop mapping, code 001 drives `cpu_halt_n` and `cpu_doze_n` (when enabled) low GAP+1 edges after the write edge and leaves the stage pins high. Code 010 then causes no transition. The mobile mapping swaps these two roles, with 010 asserting only `stage1_n`.
- R6: A go write with code 000, 011 or 100 causes no output change. The code is still stored and reads back.
- R7: A wake pulse releases the asserted stages in reverse order. The first is released GAP+1 edges after the wake edge and each of the others GAP edges later. The code field reads 000 once the last one is released.
- R8: While the sequencer is not in the on state, go writes are ignored and code-field writes are ignored.
- R9: Writing 1 to bit 2 makes `fw_event_o` high for exactly the one cycle after the write edge.
- R10: A power-management event raises `sci_o` on the next edge when bit 0 = 1, and raises `smi_o` when bit 0 = 0. The two outputs are never high together.
- R11: With bit 1 = 1, `bm_req_i` produces `idle_break_o` one edge later. With bit 1 = 0, bus-master requests are ignored.
- R12: In any one cycle at most one stage output changes, and a deeper stage is low only while every shallower stage is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| pm_event_i | input | 1 | Power-management event to route |
| bm_req_i | input | 1 | Bus-master request |
| wake_i | input | 1 | Wake request back to on state |
| sci_o | output | 1 | Routed event, SCI side |
| smi_o | output | 1 | Routed event, SMI side |
| fw_event_o | output | 1 | One-cycle event toward firmware |
| idle_break_o | output | 1 | Break out of deep processor idle |
| stage1_n | output | 1 | First sleep stage, active low |
| stage2_n | output | 1 | Second sleep stage, active low |
| stage3_n | output | 1 | Third sleep stage, active low |
| cpu_halt_n | output | 1 | Processor clock stop, active low |
| cpu_doze_n | output | 1 | Processor sleep, active low |

## Verification
The hardest case to reach is a request that arrives while the sequencer is already asleep. Both the go bit and the code field must be ignored, but a plain write from the on state never shows this. The stimulus first drives a two-stage sleep to completion. It then issues a go write with a deeper code and confirms that the pins and the stored code are unchanged several stage gaps later. Only then does it wake the block and check the reverse release against edge-counted expectations in the scoreboard.

// File: rtl/pm_sleep_pkg.sv
package pm_sleep_pkg;

  localparam int CODE_W   = 3;
  localparam int POS_SCI  = 0;
  localparam int POS_BMR  = 1;
  localparam int POS_KICK = 2;
  localparam int POS_CODE = 10;
  localparam int POS_GO   = 13;

  typedef enum logic [1:0] {
    SQ_ON     = 2'd0,
    SQ_ENTER  = 2'd1,
    SQ_ASLEEP = 2'd2,
    SQ_EXIT   = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic [1:0] depth;
    logic       halt;
  } sleep_plan_t;

  // Map a sleep code to a stage depth; depth 0 means no transition.
  function automatic sleep_plan_t plan_for(input logic [CODE_W-1:0] code,
                                           input bit mobile);
    sleep_plan_t p;
    p = '0;
    case (code)
      3'b001: if (!mobile) begin p.depth = 2'd1; p.halt = 1'b1; end
      3'b010: if (mobile) p.depth = 2'd1;
      3'b101: p.depth = 2'd2;
      3'b110,
      3'b111: p.depth = 2'd3;
      default: p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/pm_cfg_reg.sv
module pm_cfg_reg
  import pm_sleep_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  input  logic              code_wr_ok,
  input  logic              code_clr,
  output logic [DW-1:0]     rdata,
  output logic              route_sci,
  output logic              bm_wake_en,
  output logic              go_req,
  output logic              kick_req,
  output logic [CODE_W-1:0] go_code
);

  logic [CODE_W-1:0] code_q, code_d;
  logic              sci_q, sci_d;
  logic              bmr_q, bmr_d;
  logic              reg_en;

  always_comb begin
    code_d = code_q;
    sci_d  = sci_q;
    bmr_d  = bmr_q;
    if (wr) begin
      sci_d = wdata[POS_SCI];
      bmr_d = wdata[POS_BMR];
      if (code_wr_ok) code_d = wdata[POS_CODE +: CODE_W];
    end
    if (code_clr) code_d = '0;
  end

  assign reg_en = wr | code_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      sci_q  <= 1'b0;
      bmr_q  <= 1'b0;
    end else if (reg_en) begin
      code_q <= code_d;
      sci_q  <= sci_d;
      bmr_q  <= bmr_d;
    end
  end

  always_comb begin
    rdata                       = '0;
    rdata[POS_SCI]              = sci_q;
    rdata[POS_BMR]              = bmr_q;
    rdata[POS_CODE +: CODE_W]   = code_q;
  end

  assign route_sci  = sci_q;
  assign bm_wake_en = bmr_q;
  assign go_req     = wr & wdata[POS_GO];
  assign kick_req   = wr & wdata[POS_KICK];
  assign go_code    = wdata[POS_CODE +: CODE_W];

endmodule

// File: rtl/pm_sleep_seq.sv
module pm_sleep_seq
  import pm_sleep_pkg::*;
#(
  parameter int GAP        = 4,
  parameter bit MOBILE     = 1'b0,
  parameter bit USE_DOZE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_req,
  input  logic [CODE_W-1:0] go_code,
  input  logic              wake,
  output logic              is_on,
  output logic              code_clr,
  output logic              stage1_n,
  output logic              stage2_n,
  output logic              stage3_n,
  output logic              cpu_halt_n,
  output logic              cpu_doze_n
);

  localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [CW-1:0] LAST = CW'(GAP - 1);

  seq_state_t  st_q, st_d;
  logic [1:0]  lvl_q, lvl_d, tgt_q, tgt_d;
  logic        halt_q, halt_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic        tick;
  sleep_plan_t plan;
  logic        any_d;
  logic [4:0]  pins_d, pins_q;

  assign tick = (cnt_q == LAST);
  assign plan = plan_for(go_code, MOBILE);

  always_comb begin
    st_d     = st_q;
    lvl_d    = lvl_q;
    tgt_d    = tgt_q;
    halt_d   = halt_q;
    cnt_d    = cnt_q;
    code_clr = 1'b0;
    unique case (st_q)
      SQ_ON: begin
        if (go_req && plan.depth != 2'd0) begin
          st_d   = SQ_ENTER;
          tgt_d  = plan.depth;
          halt_d = plan.halt;
          cnt_d  = '0;
        end
      end
      SQ_ENTER: begin
        if (wake) begin
          st_d  = SQ_EXIT;
          cnt_d = '0;
        end else if (tick) begin
          cnt_d = '0;
          lvl_d = lvl_q + 2'd1;
          if (lvl_d == tgt_q) st_d = SQ_ASLEEP;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      SQ_ASLEEP: begin
        if (wake) begin
          st_d  = SQ_EXIT;
          cnt_d = '0;
        end
      end
      SQ_EXIT: begin
        if (lvl_q == 2'd0) begin
          st_d     = SQ_ON;
          code_clr = 1'b1;
        end else if (tick) begin
          cnt_d = '0;
          lvl_d = lvl_q - 2'd1;
          if (lvl_q == 2'd1) begin
            st_d     = SQ_ON;
            code_clr = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: st_d = SQ_ON;
    endcase
  end

  always_comb begin
    any_d     = (lvl_d != 2'd0);
    pins_d[4] = ~(any_d && !halt_d);
    pins_d[3] = ~(lvl_d >= 2'd2);
    pins_d[2] = ~(lvl_d == 2'd3);
    pins_d[1] = ~(any_d && halt_d);
    pins_d[0] = ~(any_d && halt_d && USE_DOZE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_ON;
      lvl_q  <= '0;
      tgt_q  <= '0;
      halt_q <= 1'b0;
      cnt_q  <= '0;
      pins_q <= '1;
    end else begin
      st_q   <= st_d;
      lvl_q  <= lvl_d;
      tgt_q  <= tgt_d;
      halt_q <= halt_d;
      cnt_q  <= cnt_d;
      pins_q <= pins_d;
    end
  end

  assign is_on      = (st_q == SQ_ON);
  assign stage1_n   = pins_q[4];
  assign stage2_n   = pins_q[3];
  assign stage3_n   = pins_q[2];
  assign cpu_halt_n = pins_q[1];
  assign cpu_doze_n = pins_q[0];

endmodule

// File: rtl/pm_event_route.sv
module pm_event_route (
  input  logic clk,
  input  logic rst_n,
  input  logic pm_event,
  input  logic route_sci,
  input  logic bm_req,
  input  logic bm_wake_en,
  input  logic kick_req,
  output logic sci_o,
  output logic smi_o,
  output logic idle_break_o,
  output logic fw_event_o
);

  logic sci_d, smi_d, brk_d, fw_d;

  always_comb begin
    sci_d = pm_event & route_sci;
    smi_d = pm_event & ~route_sci;
    brk_d = bm_req & bm_wake_en;
    fw_d  = kick_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sci_o        <= 1'b0;
      smi_o        <= 1'b0;
      idle_break_o <= 1'b0;
      fw_event_o   <= 1'b0;
    end else begin
      sci_o        <= sci_d;
      smi_o        <= smi_d;
      idle_break_o <= brk_d;
      fw_event_o   <= fw_d;
    end
  end

endmodule

// File: rtl/pm_sleep_ctl.sv
module pm_sleep_ctl
  import pm_sleep_pkg::*;
#(
  parameter int DW       = 32,
  parameter int GAP      = 4,
  parameter bit MOBILE   = 1'b0,
  parameter bit USE_DOZE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          pm_event_i,
  input  logic          bm_req_i,
  input  logic          wake_i,
  output logic          sci_o,
  output logic          smi_o,
  output logic          fw_event_o,
  output logic          idle_break_o,
  output logic          stage1_n,
  output logic          stage2_n,
  output logic          stage3_n,
  output logic          cpu_halt_n,
  output logic          cpu_doze_n
);

  logic [1:0]        rs_q;
  logic              rst_core_n;
  logic              route_sci, bm_wake_en, go_req, kick_req;
  logic              is_on, code_clr;
  logic [CODE_W-1:0] go_code;

  // Reset asserts at once and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  pm_cfg_reg #(.DW(DW)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr         (reg_wr),
    .wdata      (reg_wdata),
    .code_wr_ok (is_on),
    .code_clr   (code_clr),
    .rdata      (reg_rdata),
    .route_sci  (route_sci),
    .bm_wake_en (bm_wake_en),
    .go_req     (go_req),
    .kick_req   (kick_req),
    .go_code    (go_code)
  );

  pm_sleep_seq #(.GAP(GAP), .MOBILE(MOBILE), .USE_DOZE(USE_DOZE)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .go_req     (go_req),
    .go_code    (go_code),
    .wake       (wake_i),
    .is_on      (is_on),
    .code_clr   (code_clr),
    .stage1_n   (stage1_n),
    .stage2_n   (stage2_n),
    .stage3_n   (stage3_n),
    .cpu_halt_n (cpu_halt_n),
    .cpu_doze_n (cpu_doze_n)
  );

  pm_event_route u_route (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .pm_event     (pm_event_i),
    .route_sci    (route_sci),
    .bm_req       (bm_req_i),
    .bm_wake_en   (bm_wake_en),
    .kick_req     (kick_req),
    .sci_o        (sci_o),
    .smi_o        (smi_o),
    .idle_break_o (idle_break_o),
    .fw_event_o   (fw_event_o)
  );

endmodule

// File: rtl/pm_sleep_ctl_chk.sv
module pm_sleep_ctl_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          pm_event_i,
  input logic          bm_req_i,
  input logic          sci_o,
  input logic          smi_o,
  input logic          fw_event_o,
  input logic          idle_break_o,
  input logic          stage1_n,
  input logic          stage2_n,
  input logic          stage3_n,
  input logic          cpu_halt_n
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_WO_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (reg_rdata[13] == 1'b0 && reg_rdata[2] == 1'b0));                   // R2
  AST_STAGE_ORDER3: assert property (@(posedge clk) disable iff (!rst_n)
    !stage3_n |-> !stage2_n);                                                        // R12
  AST_STAGE_ORDER2: assert property (@(posedge clk) disable iff (!rst_n)
    !stage2_n |-> !stage1_n);                                                        // R12
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ($countones({stage1_n, stage2_n, stage3_n} ^
                            $past({stage1_n, stage2_n, stage3_n})) <= 1));           // R12
  AST_HALT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_halt_n |-> (stage1_n && stage2_n && stage3_n));                             // R5
  AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sci_o && smi_o));                                                              // R10
  AST_SCI_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && sci_o) |-> $past(pm_event_i && reg_rdata[0]));                       // R10
  AST_FW_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && fw_event_o) |-> $past(reg_wr && reg_wdata[2]));                      // R9
  AST_BRK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && idle_break_o) |-> $past(bm_req_i && reg_rdata[1]));                  // R11

endmodule

bind pm_sleep_ctl pm_sleep_ctl_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .pm_event_i   (pm_event_i),
  .bm_req_i     (bm_req_i),
  .sci_o        (sci_o),
  .smi_o        (smi_o),
  .fw_event_o   (fw_event_o),
  .idle_break_o (idle_break_o),
  .stage1_n     (stage1_n),
  .stage2_n     (stage2_n),
  .stage3_n     (stage3_n),
  .cpu_halt_n   (cpu_halt_n)
);

// File: tb/pm_sleep_ctl_test.sv
`timescale 1ns/1ps
module pm_sleep_ctl_test;

  localparam int G = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pm_event_i = 1'b0;
  logic        bm_req_i = 1'b0;
  logic        wake_i = 1'b0;
  logic        sci_o, smi_o, fw_event_o, idle_break_o;
  logic        stage1_n, stage2_n, stage3_n, cpu_halt_n, cpu_doze_n;
  logic [4:0]  pins;

  int cyc = 0;
  int t0 = 0;
  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int         at;
    logic [4:0] v;
    string      req;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pm_sleep_ctl #(.DW(32), .GAP(G), .MOBILE(1'b0), .USE_DOZE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pm_event_i(pm_event_i), .bm_req_i(bm_req_i),
    .wake_i(wake_i), .sci_o(sci_o), .smi_o(smi_o), .fw_event_o(fw_event_o),
    .idle_break_o(idle_break_o), .stage1_n(stage1_n), .stage2_n(stage2_n),
    .stage3_n(stage3_n), .cpu_halt_n(cpu_halt_n), .cpu_doze_n(cpu_doze_n)
  );

  assign pins = {stage1_n, stage2_n, stage3_n, cpu_halt_n, cpu_doze_n};

  function automatic void chk(input bit ok, input string req,
                              input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endfunction

  // Monitor: compares the pin vector with the scheduled expectations.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      if (q[0].at == cyc)
        chk(pins === q[0].v, q[0].req, 32'(pins), 32'(q[0].v));
      void'(q.pop_front());
    end
  end

  task automatic push(input int dly, input logic [4:0] v, input string req);
    exp_t e;
    e.at = t0 + dly; e.v = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    t0 = cyc; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic wake();
    @(negedge clk);
    t0 = cyc; wake_i = 1'b1;
    @(negedge clk);
    wake_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(reg_rdata == 32'h0, "R1 rdata", reg_rdata, 32'h0);
    chk(pins == 5'b11111, "R1 pins", 32'(pins), 32'h1F);
    chk({sci_o, smi_o, fw_event_o, idle_break_o} == 4'b0, "R1 events",
        32'({sci_o, smi_o, fw_event_o, idle_break_o}), 32'h0);

    // R2 readback, R9 firmware kick pulse
    wr(32'hFFFF_DFFF);
    chk(reg_rdata == 32'h0000_1C03, "R2 readback", reg_rdata, 32'h0000_1C03);
    chk(fw_event_o == 1'b1, "R9 pulse high", 32'(fw_event_o), 32'h1);
    @(negedge clk);
    chk(fw_event_o == 1'b0, "R9 pulse one cycle", 32'(fw_event_o), 32'h0);
    wr(32'h0);
    chk(reg_rdata == 32'h0, "R2 cleared", reg_rdata, 32'h0);

    // R10 event routing
    @(negedge clk); pm_event_i = 1'b1;
    @(negedge clk); pm_event_i = 1'b0;
    chk({sci_o, smi_o} == 2'b01, "R10 smi path", 32'({sci_o, smi_o}), 32'h1);
    wr(32'h1);
    @(negedge clk); pm_event_i = 1'b1;
    @(negedge clk); pm_event_i = 1'b0;
    chk({sci_o, smi_o} == 2'b10, "R10 sci path", 32'({sci_o, smi_o}), 32'h2);

    // R11 bus-master reload
    wr(32'h0);
    bm_req_i = 1'b1;
    repeat (2) @(negedge clk);
    chk(idle_break_o == 1'b0, "R11 ignored", 32'(idle_break_o), 32'h0);
    wr(32'h2);
    @(negedge clk);
    chk(idle_break_o == 1'b1, "R11 break", 32'(idle_break_o), 32'h1);
    bm_req_i = 1'b0;
    wr(32'h0);

    // R6 / R5: codes that cause no transition (010 is inert in desktop mapping)
    foreach (q[i]) ;
    for (int k = 0; k < 4; k++) begin
      logic [2:0] c;
      c = (k == 0) ? 3'b000 : (k == 1) ? 3'b011 : (k == 2) ? 3'b100 : 3'b010;
      wr(32'h2000 | (32'(c) << 10));
      push(3 * G + 2, 5'b11111, (k == 3) ? "R5 code010 inert" : "R6 no transition");
      drain();
      chk(reg_rdata == (32'(c) << 10), "R6 code stored", reg_rdata, 32'(c) << 10);
    end
    wr(32'h0);

    // R3 code 101
    wr(32'h0000_3400);
    push(G,         5'b11111, "R3 before stage1");
    push(G + 1,     5'b01111, "R3 stage1");
    push(2 * G,     5'b01111, "R3 hold stage1");
    push(2 * G + 1, 5'b00111, "R3 stage2");
    push(3 * G + 3, 5'b00111, "R3 no stage3");
    drain();

    // R8 request while asleep is ignored
    wr(32'h0000_3C00);
    push(3 * G + 2, 5'b00111, "R8 pins unchanged");
    drain();
    chk(reg_rdata == 32'h0000_1400, "R8 code kept", reg_rdata, 32'h0000_1400);

    // R7 wake from two stages
    wake();
    push(G,         5'b00111, "R7 before release");
    push(G + 1,     5'b01111, "R7 stage2 off");
    push(2 * G + 1, 5'b11111, "R7 stage1 off");
    drain();
    chk(reg_rdata == 32'h0, "R7 code cleared", reg_rdata, 32'h0);

    // R4 code 111
    wr(32'h0000_3C00);
    push(G + 1,     5'b01111, "R4 111 stage1");
    push(2 * G + 1, 5'b00111, "R4 111 stage2");
    push(3 * G,     5'b00111, "R4 111 before stage3");
    push(3 * G + 1, 5'b00011, "R4 111 stage3");
    drain();
    wake();
    push(G + 1,     5'b00111, "R7 stage3 off");
    push(2 * G + 1, 5'b01111, "R7 stage2 off");
    push(3 * G + 1, 5'b11111, "R7 stage1 off");
    drain();
    chk(reg_rdata == 32'h0, "R7 code cleared 111", reg_rdata, 32'h0);

    // R4 code 110
    wr(32'h0000_3800);
    push(G + 1,     5'b01111, "R4 110 stage1");
    push(2 * G + 1, 5'b00111, "R4 110 stage2");
    push(3 * G + 1, 5'b00011, "R4 110 stage3");
    drain();
    wake();
    push(3 * G + 1, 5'b11111, "R7 110 released");
    drain();

    // R5 code 001: processor halt and doze
    wr(32'h0000_2400);
    push(G,     5'b11111, "R5 before halt");
    push(G + 1, 5'b11100, "R5 halt and doze");
    push(3 * G, 5'b11100, "R5 stages untouched");
    drain();
    wake();
    push(G + 1, 5'b11111, "R5 halt released");
    drain();
    chk(reg_rdata == 32'h0, "R7 code cleared 001", reg_rdata, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule